// File: doc/BRIEF.md
# Multi-Channel DMA Channel Controller

This block keeps the programming state of a set of DMA channels and decides, one request at a time, whether a transfer may happen and how long it is. Software programs each channel through a 32-bit register port: a control word, a remaining byte count and a start address. A device-side requester presents a request that names a channel slot, a direction and a wanted length. One cycle later the block either hands the start address and a granted length to an external data mover, or reports an error.

A granted request sets the channel's terminal-count flag and reduces the count by the granted length. A refused request sets the channel's memory-error flag and latches a sticky per-slot error bit. The OR of those bits drives a non-maskable interrupt line. A request is refused when the channel is disabled, when the direction differs from the programmed one, or when the slot has no channel built. The register space has room for eight channel slots. By default only four hold real channels.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel register and the error source register read as zero, and `nmi`, `xfer_go` and `req_err` are low.
- R2: The channel for slot n sits at byte offset 0x100 + 0x20*n. Address bits [4:3] select the register: 1 is control, 2 is byte count, 3 is start address. Address bits [2:0] are ignored. Register index 0, and every register of a slot at or above the number of built channels, reads zero and ignores writes. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R3: Every request first clears control bits 8 (terminal count), 9 (memory error) and 10 (address error) of its channel.
- R4: If control bit 0 (enable) is clear, the request is refused. Control bit 9 is set, bit n of the error source register is set, the count is left unchanged, `req_err` pulses one cycle after the request, and `xfer_go` stays low.
- R5: If `req_to_dev` differs from control bit 1 (1 = memory to device, 0 = device to memory), the request is refused exactly as in R4.
- R6: An accepted request raises `xfer_go` for one cycle, one cycle after `req_valid`. With it, `xfer_chan` carries the slot, `xfer_addr` the start address, and `xfer_len` the smaller of `req_len` and the remaining count. This also covers a count of zero, which grants length zero.
- R7: After an accepted request, control bit 8 is set and the count is reduced by the granted length. The address register is unchanged.
- R8: The error source register reads at offset 0x200, with slot n in bit n. Its bits are only ever set, are cleared only by reset, and ignore writes. `nmi` is high exactly when any bit is set.
- R9: A request to a slot at or above the number of built channels is refused and sets that slot's error source bit.
- R10: A register write in the same cycle as a request to the same channel wins over the request's update of that register. The transfer response is still computed from the values held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| req_valid | input | 1 | Transfer request strobe |
| req_chan | input | SLOT_W | Requested channel slot |
| req_to_dev | input | 1 | 1 = memory to device, 0 = device to memory |
| req_len | input | 32 | Requested length in bytes |
| xfer_go | output | 1 | Transfer granted |
| xfer_chan | output | SLOT_W | Slot of the granted or refused request |
| xfer_addr | output | 32 | Start address for the data mover |
| xfer_len | output | 32 | Granted length |
| req_err | output | 1 | Request refused |
| nmi | output | 1 | OR of the error source bits |

## Verification
Requests are issued in several patterns, and each pattern separates a different decision of the block. A request shorter than the count shows a plain grant. A request longer than the count shows the clamp. A request on an exhausted channel shows the zero-length grant. A request with the wrong direction, one to a disabled channel and one to an empty slot each take their own refusal path. Flags that software planted before a request show the clearing step. A write that lands in the same cycle as a request shows which of the two wins. Register reads after each step show that the count, the flags and the error source bits moved exactly as the requirements say.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int DATA_W       = 32;
    typedef logic [DATA_W-1:0] word_t;

    // control word bit positions
    localparam int CTL_EN       = 0;
    localparam int CTL_TODEV    = 1;
    localparam int FLG_TC       = 8;
    localparam int FLG_MEM      = 9;
    localparam int FLG_ADDR     = 10;

    // address map
    localparam int CH_BASE      = 'h100;
    localparam int CH_STRIDE_LG = 5;
    localparam int CH_STRIDE    = 1 << CH_STRIDE_LG;
    localparam int IDX_LSB      = 3;
    localparam int ERRSRC_OFF   = 'h200;

    typedef enum logic [1:0] {
        RIDX_SPARE = 2'd0,
        RIDX_CTRL  = 2'd1,
        RIDX_CNT   = 2'd2,
        RIDX_ADDR  = 2'd3
    } ridx_e;

    typedef struct packed {
        word_t ctrl;
        word_t cnt;
        word_t base;
    } chan_regs_t;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_ctrl,
    input  logic  wr_cnt,
    input  logic  wr_base,
    input  word_t wdata,
    input  logic  req_hit,
    input  logic  req_to_dev,
    input  word_t req_len,
    output word_t ctrl_o,
    output word_t cnt_o,
    output word_t base_o,
    output logic  ok_o,
    output word_t gnt_len_o
);
    chan_regs_t regs_d, regs_q;
    logic       ok;
    word_t      gnt;

    always_comb begin
        ok     = regs_q.ctrl[CTL_EN] && (regs_q.ctrl[CTL_TODEV] == req_to_dev);
        gnt    = (req_len < regs_q.cnt) ? req_len : regs_q.cnt;
        regs_d = regs_q;
        if (req_hit) begin
            regs_d.ctrl[FLG_TC]   = 1'b0;
            regs_d.ctrl[FLG_MEM]  = 1'b0;
            regs_d.ctrl[FLG_ADDR] = 1'b0;
            if (ok) begin
                regs_d.ctrl[FLG_TC] = 1'b1;
                regs_d.cnt          = regs_q.cnt - gnt;
            end else begin
                regs_d.ctrl[FLG_MEM] = 1'b1;
            end
        end
        // software write wins over the request update
        if (wr_ctrl) regs_d.ctrl = wdata;
        if (wr_cnt)  regs_d.cnt  = wdata;
        if (wr_base) regs_d.base = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl_o    = regs_q.ctrl;
    assign cnt_o     = regs_q.cnt;
    assign base_o    = regs_q.base;
    assign ok_o      = ok;
    assign gnt_len_o = gnt;

    AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && !ok_o && !wr_ctrl) |=> (regs_q.ctrl[FLG_MEM] && !regs_q.ctrl[FLG_TC])); // R4
    AST_GRANT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && ok_o && !wr_ctrl) |=> (regs_q.ctrl[FLG_TC] && !regs_q.ctrl[FLG_MEM] && !regs_q.ctrl[FLG_ADDR])); // R3
    AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> (regs_q.cnt <= $past(regs_q.cnt))); // R7
endmodule

// File: rtl/dmac_errsrc.sv
module dmac_errsrc #(
    parameter int NUM_SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] set_vec,
    output logic [NUM_SLOTS-1:0] src_o,
    output logic                 nmi_o
);
    logic [NUM_SLOTS-1:0] src_d, src_q;

    always_comb begin
        src_d = src_q | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_d;
    end

    assign src_o = src_q;
    assign nmi_o = |src_q;

    AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((~src_q & $past(src_q)) == '0)); // R8
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> nmi_o); // R8
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_SLOTS = 8,
    parameter int ADDR_W    = 10,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [SLOT_W-1:0] req_chan,
    input  logic              req_to_dev,
    input  logic [31:0]       req_len,
    output logic              xfer_go,
    output logic [SLOT_W-1:0] xfer_chan,
    output logic [31:0]       xfer_addr,
    output logic [31:0]       xfer_len,
    output logic              req_err,
    output logic              nmi
);
    localparam int CH_END = CH_BASE + NUM_SLOTS * CH_STRIDE;

    typedef struct packed {
        logic              go;
        logic              err;
        logic [SLOT_W-1:0] chan;
        word_t             addr;
        word_t             len;
        word_t             rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              in_win;
    logic              errsrc_hit;
    logic [SLOT_W-1:0] slot_a;
    ridx_e             idx_a;
    logic              unused_addr_bits;

    word_t ctrl_v [NUM_SLOTS];
    word_t cnt_v  [NUM_SLOTS];
    word_t base_v [NUM_SLOTS];
    word_t gnt_v  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] ok_v;
    logic [NUM_SLOTS-1:0] hit_v;
    logic [NUM_SLOTS-1:0] err_v;
    logic [NUM_SLOTS-1:0] errsrc;
    logic                 nmi_w;

    assign in_win     = (int'(reg_addr) >= CH_BASE) && (int'(reg_addr) < CH_END);
    assign errsrc_hit = (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(ERRSRC_OFF >> 2));
    assign slot_a     = reg_addr[CH_STRIDE_LG +: SLOT_W];
    assign idx_a      = ridx_e'(reg_addr[IDX_LSB +: 2]);
    assign unused_addr_bits = ^reg_addr[2:0];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic sel;
        assign sel      = reg_wr && in_win && (slot_a == SLOT_W'(i));
        assign hit_v[i] = req_valid && (req_chan == SLOT_W'(i));
        assign err_v[i] = hit_v[i] && !ok_v[i];
        if (i < NUM_CH) begin : g_live
            dmac_chan u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_ctrl    (sel && (idx_a == RIDX_CTRL)),
                .wr_cnt     (sel && (idx_a == RIDX_CNT)),
                .wr_base    (sel && (idx_a == RIDX_ADDR)),
                .wdata      (reg_wdata),
                .req_hit    (hit_v[i]),
                .req_to_dev (req_to_dev),
                .req_len    (req_len),
                .ctrl_o     (ctrl_v[i]),
                .cnt_o      (cnt_v[i]),
                .base_o     (base_v[i]),
                .ok_o       (ok_v[i]),
                .gnt_len_o  (gnt_v[i])
            );
        end else begin : g_empty
            logic unused_sel;
            assign unused_sel = sel;
            assign ctrl_v[i]  = '0;
            assign cnt_v[i]   = '0;
            assign base_v[i]  = '0;
            assign gnt_v[i]   = '0;
            assign ok_v[i]    = 1'b0;
        end
    end

    dmac_errsrc #(.NUM_SLOTS(NUM_SLOTS)) u_errsrc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (err_v),
        .src_o   (errsrc),
        .nmi_o   (nmi_w)
    );

    always_comb begin
        word_t rd_val;
        rd_val = '0;
        if (in_win) begin
            unique case (idx_a)
                RIDX_CTRL:  rd_val = ctrl_v[slot_a];
                RIDX_CNT:   rd_val = cnt_v[slot_a];
                RIDX_ADDR:  rd_val = base_v[slot_a];
                default:    rd_val = '0;
            endcase
        end else if (errsrc_hit) begin
            rd_val[NUM_SLOTS-1:0] = errsrc;
        end

        st_d       = st_q;
        st_d.go    = req_valid && ok_v[req_chan];
        st_d.err   = req_valid && !ok_v[req_chan];
        st_d.chan  = req_chan;
        st_d.addr  = st_d.go ? base_v[req_chan] : '0;
        st_d.len   = st_d.go ? gnt_v[req_chan]  : '0;
        if (reg_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign xfer_go   = st_q.go;
    assign req_err   = st_q.err;
    assign xfer_chan = st_q.chan;
    assign xfer_addr = st_q.addr;
    assign xfer_len  = st_q.len;
    assign nmi       = nmi_w;

    AST_GO_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_go && req_err)); // R4
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (xfer_go || req_err)); // R6
    AST_GRANT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> (xfer_len <= $past(req_len))); // R6
    AST_ERR_RAISES_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> nmi); // R8
endmodule

// File: tb/tb_dma_chan_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chan_ctrl;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [2:0]  req_chan = '0;
    logic        req_to_dev = 1'b0;
    logic [31:0] req_len = '0;
    logic        xfer_go, req_err, nmi;
    logic [2:0]  xfer_chan;
    logic [31:0] xfer_addr, xfer_len;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dma_chan_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_chan(req_chan), .req_to_dev(req_to_dev),
        .req_len(req_len),
        .xfer_go(xfer_go), .xfer_chan(xfer_chan), .xfer_addr(xfer_addr),
        .xfer_len(xfer_len), .req_err(req_err), .nmi(nmi)
    );

    // requirement-level model
    logic [31:0] m_ctrl [8];
    logic [31:0] m_cnt  [8];
    logic [31:0] m_addr [8];
    logic [7:0]  m_src;

    typedef struct {
        logic        err;
        logic [2:0]  ch;
        logic [31:0] addr;
        logic [31:0] len;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_wr(logic [9:0] a, logic [31:0] d);
        int s, x;
        if (a >= 10'h100 && a < 10'h200) begin
            s = int'(a[7:5]);
            x = int'(a[4:3]);
            if (s < NCH) begin
                if (x == 1) m_ctrl[s] = d;
                if (x == 2) m_cnt[s]  = d;
                if (x == 3) m_addr[s] = d;
            end
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        model_wr(a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [9:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(tag, reg_rdata, exp);
    endtask

    // driver: computes the expected response, pushes it, drives one request
    task automatic do_req(int ch, bit todev, logic [31:0] len, string tag,
                          bit wr_too = 0, logic [9:0] wa = '0, logic [31:0] wd = '0);
        exp_t e;
        bit ok;
        logic [31:0] g;
        ok = (ch < NCH) && m_ctrl[ch][0] && (m_ctrl[ch][1] == todev);
        g  = (ch < NCH && len < m_cnt[ch]) ? len : ((ch < NCH) ? m_cnt[ch] : 32'd0);
        e.err = !ok; e.ch = 3'(ch); e.addr = (ch < NCH) ? m_addr[ch] : '0; e.len = g; e.tag = tag;
        sb.push_back(e);
        if (ch < NCH) m_ctrl[ch][10:8] = 3'b000;
        if (ok) begin
            m_ctrl[ch][8] = 1'b1;
            m_cnt[ch]     = m_cnt[ch] - g;
        end else begin
            if (ch < NCH) m_ctrl[ch][9] = 1'b1;
            m_src[ch] = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b1; req_chan = 3'(ch); req_to_dev = todev; req_len = len;
        if (wr_too) begin
            reg_wr = 1'b1; reg_addr = wa; reg_wdata = wd;
            model_wr(wa, wd);
        end
        @(negedge clk);
        req_valid = 1'b0; reg_wr = 1'b0;
    endtask

    // monitor: pops and compares as responses appear
    always @(negedge clk) begin
        if (rst_n && (xfer_go || req_err)) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R6: actual=unexpected response expected=none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " err"}, {31'd0, req_err}, {31'd0, e.err});
                check({e.tag, " go"}, {31'd0, xfer_go}, {31'd0, !e.err});
                check({e.tag, " chan"}, {29'd0, xfer_chan}, {29'd0, e.ch});
                if (!e.err) begin
                    check({e.tag, " addr"}, xfer_addr, e.addr);
                    check({e.tag, " len"}, xfer_len, e.len);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_ctrl[i] = '0; m_cnt[i] = '0; m_addr[i] = '0;
        end
        m_src = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 nmi", {31'd0, nmi}, 32'd0);
        check("R1 go", {31'd0, xfer_go}, 32'd0);
        check("R1 err", {31'd0, req_err}, 32'd0);
        rd_chk(10'h108, 32'd0, "R1 ctrl0");
        rd_chk(10'h170, 32'd0, "R1 cnt3");
        rd_chk(10'h200, 32'd0, "R1 errsrc");

        // R2 programming, low address bits ignored
        wr(10'h10B, 32'h0000_0001);
        wr(10'h110, 32'd100);
        wr(10'h11D, 32'h1000_0000);
        wr(10'h128, 32'h0000_0003);
        wr(10'h130, 32'd50);
        wr(10'h138, 32'h0000_2000);
        rd_chk(10'h108, m_ctrl[0], "R2 ctrl0");
        rd_chk(10'h112, m_cnt[0], "R2 cnt0");
        rd_chk(10'h118, 32'h1000_0000, "R2 addr0");
        rd_chk(10'h138, 32'h0000_2000, "R2 addr1");
        wr(10'h100, 32'hDEAD_BEEF);
        rd_chk(10'h100, 32'd0, "R2 spare index");
        wr(10'h1A8, 32'h0000_0001);
        rd_chk(10'h1A8, 32'd0, "R2 empty slot");

        // R6/R7 plain grant
        do_req(0, 1'b0, 32'd40, "R6 grant");
        rd_chk(10'h108, 32'h0000_0101, "R7 tc flag");
        rd_chk(10'h110, 32'd60, "R7 count");
        rd_chk(10'h118, 32'h1000_0000, "R7 addr kept");
        // R6 clamp, then zero count
        do_req(0, 1'b0, 32'd200, "R6 clamp");
        rd_chk(10'h110, 32'd0, "R7 count zero");
        do_req(0, 1'b0, 32'd5, "R6 zero grant");
        rd_chk(10'h108, m_ctrl[0], "R7 tc on zero");

        // R5 direction mismatch, then R3 clear on good request
        do_req(1, 1'b0, 32'd10, "R5 mismatch");
        rd_chk(10'h128, 32'h0000_0203, "R5 mem flag");
        rd_chk(10'h130, 32'd50, "R5 count kept");
        check("R8 nmi", {31'd0, nmi}, 32'd1);
        do_req(1, 1'b1, 32'd10, "R3 after err");
        rd_chk(10'h128, 32'h0000_0103, "R3 flags cleared");

        // R3 software-planted flags cleared
        wr(10'h108, 32'h0000_0701);
        wr(10'h110, 32'd10);
        do_req(0, 1'b0, 32'd3, "R3 grant");
        rd_chk(10'h108, 32'h0000_0101, "R3 ctrl");

        // R4 disabled, R9 empty slot
        do_req(2, 1'b0, 32'd8, "R4 disabled");
        rd_chk(10'h148, 32'h0000_0200, "R4 mem flag");
        do_req(6, 1'b0, 32'd8, "R9 empty");
        rd_chk(10'h200, {24'd0, m_src}, "R8 errsrc");
        wr(10'h200, 32'd0);
        rd_chk(10'h200, 32'h0000_0046, "R8 write ignored");

        // R10 write and request together
        do_req(0, 1'b0, 32'd4, "R10 same cycle", 1'b1, 10'h110, 32'd77);
        rd_chk(10'h110, 32'd77, "R10 write wins");
        rd_chk(10'h108, 32'h0000_0101, "R10 ctrl");

        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", sb.size(), 32'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule